// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two parallel buses, A and B, each modelled as separate input, output and output-enable vectors so the whole path stays synthesizable. It holds two capture registers. The forward register takes the A-bus value on a rising edge of its capture strobe, and the reverse register takes the B-bus value on a rising edge of its own strobe. Both strobes are level inputs sampled on the system clock. Captures happen whatever the enable and select inputs are doing.

Two enable inputs set which bus or buses the block drives. One is active high and the other is active low. A select per direction picks what the driven side shows: the live value from the opposite bus, or the register that belongs to that direction. When both buses are driven and both directions are live, the two buses would feed each other. A keeper register stands in for that loop and holds the last bus state. It reloads whenever an outside driver asserts a value on either bus.

Top module: `reg_xcvr`

## Requirements
- R1: A strobe edge on `fwd_cap_i` is a cycle with `fwd_cap_i` high that follows a cycle with it low. On such an edge the forward register loads `a_in_i`, and the new value is seen from the next cycle on. A strobe held high captures only once, and the register otherwise keeps its value.
- R2: A strobe edge on `rev_cap_i`, defined the same way, loads `b_in_i` into the reverse register, which otherwise keeps its value.
- R3: Captures take place whatever the levels of `en_b_i`, `en_a_n_i`, `fwd_stored_i` and `rev_stored_i`, including while neither bus is driven.
- R4: The enable decode is taken over {`en_b_i`,`en_a_n_i`}. 01 drives neither bus. 00 drives A only. 11 drives B only. 10 drives both. A driven bus has its enable vector all ones. An undriven bus has its enable vector all zeros and its data output at zero.
- R5: With B driven and A not, `b_out_o` equals `a_in_i` in the same cycle when `fwd_stored_i` is 0. It equals the forward register when `fwd_stored_i` is 1.
- R6: With A driven and B not, `a_out_o` equals `b_in_i` in the same cycle when `rev_stored_i` is 0. It equals the reverse register when `rev_stored_i` is 1.
- R7: With both buses driven and both selects at 1, `a_out_o` shows the reverse register and `b_out_o` shows the forward register.
- R8: With both buses driven and exactly one select at 1, both buses show that direction's register. The live side copies the stored side.
- R9: With both buses driven and both selects at 0, both outputs show the keeper. In that mode the keeper loads `a_in_i` when `a_ext_i` is 1. Otherwise it loads `b_in_i` when `b_ext_i` is 1. Otherwise it holds. In every other mode the keeper loads `a_in_i` each cycle.
- R10: Synchronous active-high `rst` clears both registers and the keeper to zero. The enable decode and output routing keep working during reset.
- R11: No path inverts data. Every output bit equals its source bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en_b_i | input | 1 | B-side enable, active high |
| en_a_n_i | input | 1 | A-side enable, active low |
| fwd_stored_i | input | 1 | B shows forward register (1) or live A (0) |
| rev_stored_i | input | 1 | A shows reverse register (1) or live B (0) |
| fwd_cap_i | input | 1 | Capture strobe for the forward register |
| rev_cap_i | input | 1 | Capture strobe for the reverse register |
| a_ext_i | input | 1 | Another driver is asserting a value on bus A |
| b_ext_i | input | 1 | Another driver is asserting a value on bus B |
| a_in_i | input | W | Value seen on bus A |
| b_in_i | input | W | Value seen on bus B |
| a_out_o | output | W | Value driven onto bus A |
| a_oe_o | output | W | Per-bit drive enable for bus A |
| b_out_o | output | W | Value driven onto bus B |
| b_oe_o | output | W | Per-bit drive enable for bus B |

## Verification
The bench builds the block at its default width of 8. At that width, patterns such as 0xA5 against 0x5A and 0x3C against 0xC3 are distinct in every bit, so any inversion, bit swap or wrong-source routing shows up. A table of all sixteen enable-and-select codes runs with the two registers preloaded to different values, so every routing case yields a distinct result. Directed steps then cover a strobe held high, captures while no bus is driven, the keeper's priority between the two outside drivers, and a reset in the middle of the run.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    typedef enum logic [1:0] {
        DRV_NONE = 2'd0,
        DRV_A    = 2'd1,
        DRV_B    = 2'd2,
        DRV_BOTH = 2'd3
    } drv_e;

    typedef struct packed {
        drv_e drv;
        logic fwd_stored;
        logic rev_stored;
    } ctl_t;

    // {en_b, en_a_n}: 01 none, 00 A only, 11 B only, 10 both
    function automatic drv_e decode_drv(input logic en_b, input logic en_a_n);
        drv_e d;
        unique case ({en_b, en_a_n})
            2'b01:   d = DRV_NONE;
            2'b00:   d = DRV_A;
            2'b11:   d = DRV_B;
            default: d = DRV_BOTH;
        endcase
        return d;
    endfunction

    function automatic logic is_loopback(input ctl_t c);
        return (c.drv == DRV_BOTH) && !c.fwd_stored && !c.rev_stored;
    endfunction

    function automatic logic drives_a(input drv_e d);
        return (d == DRV_A) || (d == DRV_BOTH);
    endfunction

    function automatic logic drives_b(input drv_e d);
        return (d == DRV_B) || (d == DRV_BOTH);
    endfunction

endpackage

// File: rtl/xcvr_cap_reg.sv
module xcvr_cap_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         strobe_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic strobe_q;
    logic edge_w;

    assign edge_w = strobe_i & ~strobe_q;

    // strobe history follows the pin even during reset
    always_ff @(posedge clk) begin
        strobe_q <= strobe_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_o <= '0;
        end else if (edge_w) begin
            q_o <= d_i;
        end
    end
endmodule

// File: rtl/xcvr_keeper.sv
module xcvr_keeper #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         loop_i,
    input  logic         a_ext_i,
    input  logic         b_ext_i,
    input  logic [W-1:0] a_in_i,
    input  logic [W-1:0] b_in_i,
    output logic [W-1:0] q_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_o <= '0;
        end else if (!loop_i) begin
            q_o <= a_in_i;
        end else if (a_ext_i) begin
            q_o <= a_in_i;
        end else if (b_ext_i) begin
            q_o <= b_in_i;
        end
    end
endmodule

// File: rtl/xcvr_route.sv
module xcvr_route
    import xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  ctl_t         ctl_i,
    input  logic [W-1:0] a_in_i,
    input  logic [W-1:0] b_in_i,
    input  logic [W-1:0] fwd_q_i,
    input  logic [W-1:0] rev_q_i,
    input  logic [W-1:0] keep_q_i,
    output logic [W-1:0] a_out_o,
    output logic [W-1:0] a_oe_o,
    output logic [W-1:0] b_out_o,
    output logic [W-1:0] b_oe_o
);
    logic         a_drv;
    logic         b_drv;
    logic [W-1:0] a_val;
    logic [W-1:0] b_val;

    assign a_drv = drives_a(ctl_i.drv);
    assign b_drv = drives_b(ctl_i.drv);

    always_comb begin
        a_val = '0;
        b_val = '0;
        unique case (ctl_i.drv)
            DRV_A: a_val = ctl_i.rev_stored ? rev_q_i : b_in_i;
            DRV_B: b_val = ctl_i.fwd_stored ? fwd_q_i : a_in_i;
            DRV_BOTH: begin
                unique case ({ctl_i.rev_stored, ctl_i.fwd_stored})
                    2'b11: begin a_val = rev_q_i;  b_val = fwd_q_i;  end
                    2'b10: begin a_val = rev_q_i;  b_val = rev_q_i;  end
                    2'b01: begin a_val = fwd_q_i;  b_val = fwd_q_i;  end
                    default: begin a_val = keep_q_i; b_val = keep_q_i; end
                endcase
            end
            default: ;
        endcase
    end

    assign a_out_o = a_drv ? a_val : '0;
    assign b_out_o = b_drv ? b_val : '0;
    assign a_oe_o  = {W{a_drv}};
    assign b_oe_o  = {W{b_drv}};
endmodule

// File: rtl/reg_xcvr.sv
module reg_xcvr
    import xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en_b_i,
    input  logic         en_a_n_i,
    input  logic         fwd_stored_i,
    input  logic         rev_stored_i,
    input  logic         fwd_cap_i,
    input  logic         rev_cap_i,
    input  logic         a_ext_i,
    input  logic         b_ext_i,
    input  logic [W-1:0] a_in_i,
    input  logic [W-1:0] b_in_i,
    output logic [W-1:0] a_out_o,
    output logic [W-1:0] a_oe_o,
    output logic [W-1:0] b_out_o,
    output logic [W-1:0] b_oe_o
);
    localparam int NDIR = 2;

    ctl_t         ctl;
    logic [W-1:0] fwd_q;
    logic [W-1:0] rev_q;
    logic [W-1:0] keep_q;
    logic         cap_stb [NDIR];
    logic [W-1:0] cap_d   [NDIR];
    logic [W-1:0] cap_q   [NDIR];

    assign ctl.drv        = decode_drv(en_b_i, en_a_n_i);
    assign ctl.fwd_stored = fwd_stored_i;
    assign ctl.rev_stored = rev_stored_i;

    // index 0: forward (A sampled), index 1: reverse (B sampled)
    assign cap_stb[0] = fwd_cap_i;
    assign cap_d[0]   = a_in_i;
    assign cap_stb[1] = rev_cap_i;
    assign cap_d[1]   = b_in_i;

    for (genvar g = 0; g < NDIR; g++) begin : g_cap
        xcvr_cap_reg #(.W(W)) cap_i (
            .clk      (clk),
            .rst      (rst),
            .strobe_i (cap_stb[g]),
            .d_i      (cap_d[g]),
            .q_o      (cap_q[g])
        );
    end

    assign fwd_q = cap_q[0];
    assign rev_q = cap_q[1];

    xcvr_keeper #(.W(W)) keep_i (
        .clk     (clk),
        .rst     (rst),
        .loop_i  (is_loopback(ctl)),
        .a_ext_i (a_ext_i),
        .b_ext_i (b_ext_i),
        .a_in_i  (a_in_i),
        .b_in_i  (b_in_i),
        .q_o     (keep_q)
    );

    xcvr_route #(.W(W)) route_i (
        .ctl_i    (ctl),
        .a_in_i   (a_in_i),
        .b_in_i   (b_in_i),
        .fwd_q_i  (fwd_q),
        .rev_q_i  (rev_q),
        .keep_q_i (keep_q),
        .a_out_o  (a_out_o),
        .a_oe_o   (a_oe_o),
        .b_out_o  (b_out_o),
        .b_oe_o   (b_oe_o)
    );
endmodule

// File: rtl/reg_xcvr_chk.sv
module reg_xcvr_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         en_b_i,
    input logic         en_a_n_i,
    input logic         fwd_stored_i,
    input logic         rev_stored_i,
    input logic         fwd_cap_i,
    input logic         rev_cap_i,
    input logic         a_ext_i,
    input logic         b_ext_i,
    input logic [W-1:0] a_in_i,
    input logic [W-1:0] b_in_i,
    input logic [W-1:0] a_out_o,
    input logic [W-1:0] a_oe_o,
    input logic [W-1:0] b_out_o,
    input logic [W-1:0] b_oe_o,
    input logic [W-1:0] fwd_q,
    input logic [W-1:0] rev_q,
    input logic [W-1:0] keep_q
);
    logic loop_mode;
    assign loop_mode = en_b_i && !en_a_n_i && !fwd_stored_i && !rev_stored_i;

    assert_fwd_cap_R1: assert property (@(posedge clk) disable iff (rst)
        (fwd_cap_i && !$past(fwd_cap_i)) |=> (fwd_q == $past(a_in_i)));

    assert_fwd_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !(fwd_cap_i && !$past(fwd_cap_i)) |=> $stable(fwd_q));

    assert_rev_cap_R2: assert property (@(posedge clk) disable iff (rst)
        (rev_cap_i && !$past(rev_cap_i)) |=> (rev_q == $past(b_in_i)));

    assert_rev_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !(rev_cap_i && !$past(rev_cap_i)) |=> $stable(rev_q));

    assert_oe_none_R4: assert property (@(posedge clk) disable iff (rst)
        (!en_b_i && en_a_n_i) |-> (a_oe_o == '0 && b_oe_o == '0 && a_out_o == '0 && b_out_o == '0));

    assert_oe_both_R4: assert property (@(posedge clk) disable iff (rst)
        (en_b_i && !en_a_n_i) |-> (a_oe_o == '1 && b_oe_o == '1));

    assert_live_b_R5: assert property (@(posedge clk) disable iff (rst)
        (en_b_i && en_a_n_i && !fwd_stored_i) |-> (b_out_o == a_in_i));

    assert_live_a_R6: assert property (@(posedge clk) disable iff (rst)
        (!en_b_i && !en_a_n_i && !rev_stored_i) |-> (a_out_o == b_in_i));

    assert_cross_R7: assert property (@(posedge clk) disable iff (rst)
        (en_b_i && !en_a_n_i && fwd_stored_i && rev_stored_i) |-> (a_out_o == rev_q && b_out_o == fwd_q));

    assert_keep_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (loop_mode && !a_ext_i && !b_ext_i) |=> $stable(keep_q));

    assert_reset_clear_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (fwd_q == '0 && rev_q == '0 && keep_q == '0));
endmodule

bind reg_xcvr reg_xcvr_chk #(.W(W)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .en_b_i       (en_b_i),
    .en_a_n_i     (en_a_n_i),
    .fwd_stored_i (fwd_stored_i),
    .rev_stored_i (rev_stored_i),
    .fwd_cap_i    (fwd_cap_i),
    .rev_cap_i    (rev_cap_i),
    .a_ext_i      (a_ext_i),
    .b_ext_i      (b_ext_i),
    .a_in_i       (a_in_i),
    .b_in_i       (b_in_i),
    .a_out_o      (a_out_o),
    .a_oe_o       (a_oe_o),
    .b_out_o      (b_out_o),
    .b_oe_o       (b_oe_o),
    .fwd_q        (fwd_q),
    .rev_q        (rev_q),
    .keep_q       (keep_q)
);

// File: tb/reg_xcvr_tb_top.sv
module reg_xcvr_tb_top;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en_b = 1'b0, en_a_n = 1'b1, fsel = 1'b0, rsel = 1'b0;
    logic         fcap = 1'b0, rcap = 1'b0, aext = 1'b0, bext = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [W-1:0] a_out, a_oe, b_out, b_oe;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // bench model state
    logic [W-1:0] m_fwd = '0, m_rev = '0, m_keep = '0;
    logic         m_pf = 1'b0, m_pr = 1'b0;

    always #5 clk = ~clk;

    reg_xcvr #(.W(W)) dut_i (
        .clk(clk), .rst(rst), .en_b_i(en_b), .en_a_n_i(en_a_n),
        .fwd_stored_i(fsel), .rev_stored_i(rsel),
        .fwd_cap_i(fcap), .rev_cap_i(rcap), .a_ext_i(aext), .b_ext_i(bext),
        .a_in_i(a_in), .b_in_i(b_in),
        .a_out_o(a_out), .a_oe_o(a_oe), .b_out_o(b_out), .b_oe_o(b_oe)
    );

    // model update from the requirements (R1, R2, R9, R10)
    always @(posedge clk) begin
        logic loop;
        loop = en_b && !en_a_n && !fsel && !rsel;
        if (rst) begin
            m_fwd = '0; m_rev = '0; m_keep = '0;
        end else begin
            if (fcap && !m_pf) m_fwd = a_in;
            if (rcap && !m_pr) m_rev = b_in;
            if (!loop)     m_keep = a_in;
            else if (aext) m_keep = a_in;
            else if (bext) m_keep = b_in;
        end
        m_pf = fcap;
        m_pr = rcap;
    end

    // stimulus table: {en_b, en_a_n, fsel, rsel, a_in, b_in}
    localparam logic [19:0] TAB [16] = '{
        {4'h0, 8'h5A, 8'hC3}, {4'h1, 8'h5A, 8'hC3}, {4'h2, 8'h0F, 8'hF0}, {4'h3, 8'h81, 8'h7E},
        {4'h4, 8'h5A, 8'hC3}, {4'h5, 8'h12, 8'h34}, {4'h6, 8'h99, 8'h66}, {4'h7, 8'hFF, 8'h00},
        {4'h8, 8'h5A, 8'hC3}, {4'h9, 8'h00, 8'hFF}, {4'hA, 8'h33, 8'hCC}, {4'hB, 8'h44, 8'hBB},
        {4'hC, 8'h5A, 8'hC3}, {4'hD, 8'hE1, 8'h1E}, {4'hE, 8'h0F, 8'hF0}, {4'hF, 8'h6D, 8'h92}
    };

    task automatic apply_check(
        input logic eb, input logic ean, input logic fs, input logic rs,
        input logic [W-1:0] ai, input logic [W-1:0] bi,
        input logic fc, input logic rc, input logic ae, input logic be,
        input string tag
    );
        logic [W-1:0] ea, eb_v, eoa, eob;
        logic da, db;
        @(negedge clk);
        en_b = eb; en_a_n = ean; fsel = fs; rsel = rs;
        a_in = ai; b_in = bi; fcap = fc; rcap = rc; aext = ae; bext = be;
        #1;
        // R4 decode
        da = (!eb && !ean) || (eb && !ean);
        db = (eb && ean) || (eb && !ean);
        ea = '0; eb_v = '0;
        if (da && !db)      ea   = rs ? m_rev : bi;     // R6
        else if (db && !da) eb_v = fs ? m_fwd : ai;     // R5
        else if (da && db) begin
            if (rs && fs)      begin ea = m_rev;  eb_v = m_fwd;  end  // R7
            else if (rs)       begin ea = m_rev;  eb_v = m_rev;  end  // R8
            else if (fs)       begin ea = m_fwd;  eb_v = m_fwd;  end  // R8
            else               begin ea = m_keep; eb_v = m_keep; end  // R9
        end
        eoa = {W{da}};
        eob = {W{db}};
        n_run++;
        if (a_out !== ea || b_out !== eb_v || a_oe !== eoa || b_oe !== eob) begin
            n_fail++;
            $display("FAIL %s: got a=%h aoe=%h b=%h boe=%h, expected a=%h aoe=%h b=%h boe=%h",
                     tag, a_out, a_oe, b_out, b_oe, ea, eoa, eb_v, eob);
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // R10: reset clears registers; routing still decoded during reset
        rst = 1'b1;
        apply_check(1, 0, 1, 1, 8'hAA, 8'h55, 0, 0, 0, 0, "R10 reset-first");
        apply_check(1, 0, 1, 1, 8'hAA, 8'h55, 1, 1, 0, 0, "R10 reset-held");
        apply_check(1, 0, 1, 1, 8'hAA, 8'h55, 0, 0, 0, 0, "R10 reset-cleared");
        @(negedge clk);
        rst = 1'b0;

        // R3: captures with neither bus driven, selects live
        apply_check(0, 1, 0, 0, 8'hA5, 8'h3C, 1, 1, 0, 0, "R3 capture-undriven");
        apply_check(0, 1, 0, 0, 8'h00, 8'h00, 0, 0, 0, 0, "R3 after-capture");
        // R1 R2 R7 R11: stored cross shows captured values unchanged
        apply_check(1, 0, 1, 1, 8'h00, 8'h00, 0, 0, 0, 0, "R7 R1 R2 cross");

        // R4 R5 R6 R8 R9: walk all enable/select codes
        for (int i = 0; i < 16; i++) begin
            apply_check(TAB[i][19], TAB[i][18], TAB[i][17], TAB[i][16],
                        TAB[i][15:8], TAB[i][7:0], 0, 0, 0, 0, $sformatf("R4 table[%0d]", i));
        end

        // R1: held-high strobe captures once
        apply_check(1, 1, 1, 0, 8'h11, 8'h00, 1, 0, 0, 0, "R1 strobe-rise");
        apply_check(1, 1, 1, 0, 8'h22, 8'h00, 1, 0, 0, 0, "R1 strobe-held");
        apply_check(1, 1, 1, 0, 8'h33, 8'h00, 0, 0, 0, 0, "R1 no-recapture");
        // R2 R3: reverse capture while A driven live
        apply_check(0, 0, 0, 0, 8'h00, 8'h6C, 0, 1, 0, 0, "R2 R3 rev-capture");
        apply_check(0, 0, 0, 1, 8'h00, 8'h00, 0, 0, 0, 0, "R2 rev-shown");
        // R8: mixed both-driven
        apply_check(1, 0, 1, 0, 8'hEE, 8'hDD, 0, 0, 0, 0, "R8 fwd-stored");
        apply_check(1, 0, 0, 1, 8'hEE, 8'hDD, 0, 0, 0, 0, "R8 rev-stored");

        // R9: keeper loopback
        apply_check(1, 0, 0, 0, 8'h77, 8'h88, 0, 0, 1, 1, "R9 enter-loop");
        apply_check(1, 0, 0, 0, 8'h00, 8'h88, 0, 0, 0, 1, "R9 a-priority");
        apply_check(1, 0, 0, 0, 8'h00, 8'h00, 0, 0, 0, 0, "R9 b-load");
        apply_check(1, 0, 0, 0, 8'hFF, 8'hFF, 0, 0, 0, 0, "R9 hold");
        apply_check(1, 0, 0, 0, 8'h00, 8'h00, 0, 0, 0, 0, "R9 hold-again");

        // R10: mid-run reset
        @(negedge clk);
        rst = 1'b1;
        apply_check(1, 0, 1, 1, 8'h00, 8'h00, 0, 0, 0, 0, "R10 mid-reset");
        @(negedge clk);
        rst = 1'b0;
        apply_check(1, 0, 1, 1, 8'h00, 8'h00, 0, 0, 0, 0, "R10 after-reset");
        apply_check(1, 0, 0, 0, 8'h00, 8'h00, 0, 0, 0, 0, "R10 keeper-cleared");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule